// File: doc/BRIEF.md
# Paged NOR Flash Command Sequencer

This block sits between a host and a byte-wide, command-driven parallel NOR flash that is visible only through a 256 KiB window. An 8-bit system register picks which of eight pages the window shows. The host issues one request at a time over a valid/ready handshake. A request can read a byte, program a byte, erase one 64 KiB zone, or erase the whole device. The block turns the request into a sequence of flash bus cycles. It first writes the page field of the system register and then sends the command bytes. For program and erase it then polls the status byte until the device reports ready and checks the failure bits. Every program or erase finishes with the status-clear command followed by the return-to-array command.

Each request ends with a one-cycle `done` pulse. `err` flags a failed request, and `rdata` holds the byte that a read returned. A 32-bit mask records the zones that are no longer trustworthy. A failed single-zone erase marks only that zone. A failed erase-all, or a program that fails on the device, marks every zone. Program requests are screened before any command is sent. A request that would need a bit to go from 0 to 1 is refused, and a byte that already holds the requested value is left alone. A byte that is programmed is read back and compared with the data.

The linear address is 21 bits: the page in bits 20:18 and the window offset in bits 17:0. A run of consecutive addresses therefore rolls from offset 0x3FFFF of one page to offset 0 of the next page.

Top module: `pnor_seq`

## Requirements
- R1: A read request (op code 0) writes the system register with `(sys_reg_in & 0x8F) | (page << 4)`, where page is address bits 20:18. It then returns the flash byte at offset bits 17:0, with `err` low. The address that follows offset 0x3FFFF of page p reads offset 0 of page p+1.
- R2: A read or program request with any of address bits 23:21 set ends with `err` high. It writes neither the system register nor the flash bus.
- R3: A program request (op code 1) whose data has a 1 where the stored byte has a 0 ends with `err` high. No flash write is issued and the unusable mask does not change.
- R4: A program request whose data equals the stored byte ends with `err` low and no flash write.
- R5: A program request that only clears bits issues exactly four flash writes: 0x10, the data, 0x50 and 0xFF. It polls status in between, ends with `err` low, and leaves the new byte in the array.
- R6: Status bit 7 set means ready. At ready, any of status bits 5, 4 or 3 set makes the operation fail. A program that fails this way ends with `err` high and sets all 32 mask bits.
- R7: After a successful program sequence the byte is read back. A byte that differs from the data gives `err` high and leaves the mask unchanged.
- R8: An erase-zone request (op code 2, zone in address bits 7:0) selects page zone>>2 and window offset (zone&3)·0x10000. It issues 0x20 and then 0xD0 on consecutive cycles, then polls, then sends 0x50 and 0xFF. A zone number above 31 ends with `err` high and no system-register write.
- R9: A single-zone erase that fails or times out ends with `err` high and sets only that zone's mask bit. Bits already set stay set.
- R10: An erase-all request (op code 3) erases zones 0 to 31 in ascending order. On the first failure it ends with `err` high, sets all mask bits and erases no further zone.
- R11: A status poll that does not see ready within PROG_TMO polls (program) or ERASE_TMO polls (erase) ends the operation as a failure. The clear-status and array-mode writes are still issued.
- R12: Every program or erase sequence ends with a write of 0x50 followed on the next cycle by 0xFF to the same window offset.
- R13: `req_ready` is high only while the block is idle. `done` is a single-cycle pulse, after which the block is ready again. Reset clears the mask and raises `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; the request is taken on this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 erase zone, 3 erase all |
| req_addr | input | ADDR_W | Linear byte address, or zone number in bits 7:0 |
| req_wdata | input | 8 | Program data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with done) |
| rdata | output | 8 | Byte returned by a read |
| unusable | output | 32 | One bit per zone that is no longer trustworthy |
| sys_reg_in | input | 8 | Current system register value |
| sys_reg_wdata | output | 8 | New system register value |
| sys_reg_we | output | 1 | System register write strobe |
| fl_addr | output | OFF_W | Window offset on the flash bus |
| fl_wdata | output | 8 | Command or data byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the cycle of fl_re |

## Verification
The bench reads the last byte of every page and the byte after it. A design that wraps the offset without moving to the next page would read the wrong page's data there. It drives program requests through all three screening outcomes on bytes spread across pages and blocks. A design that compared the wrong way round would issue command writes for refused or unchanged bytes, and a design that skipped the read-back would miss a byte the device silently failed to program. It injects status failures, hung polls and a failure in the middle of an erase-all. These show up the classic mistakes: marking all zones when one zone erase fails, carrying on past the failing zone, polling for the wrong number of cycles, or skipping the clear-status and array-mode cleanup when the operation fails.

// File: rtl/pnor_pkg.sv
// Shared types and constants for the paged NOR flash sequencer.
// Assumes a byte-wide command-set flash and an 8-bit system register whose
// bits 6:4 hold the window page.
package pnor_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_ERZ  = 2'd2,
        OP_ERA  = 2'd3
    } op_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_PROG   = 8'h10;
    localparam logic [7:0] CMD_CLRST  = 8'h50;
    localparam logic [7:0] CMD_ESETUP = 8'h20;
    localparam logic [7:0] CMD_ECONF  = 8'hD0;

    localparam int         ST_READY_BIT = 7;
    localparam logic [7:0] ST_ERR_MASK  = 8'h38;
    localparam logic [7:0] SYS_KEEP     = 8'h8F;
    localparam int         SYS_PAGE_LSB = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_PAGE, S_RD, S_PRD, S_PCMD, S_PDAT,
        S_ECMD1, S_ECMD2, S_POLL, S_CLR, S_RDM, S_VRF, S_DONE
    } state_e;

endpackage

// File: rtl/pnor_addr_map.sv
// Address decoder: turns a linear byte address or a zone number into the
// window page, the window offset and a range error.
// Assumes ZSEL_W > PAGE_W + BLK_W and ADDR_W > OFF_W + PAGE_W.
module pnor_addr_map
    import pnor_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 3,
    parameter int OFF_W  = 18,
    parameter int BLK_W  = 2,
    parameter int ZSEL_W = 8
) (
    input  op_e                op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ZSEL_W-1:0]  zone,
    output logic [PAGE_W-1:0]  page,
    output logic [OFF_W-1:0]   offset,
    output logic               range_err
);
    localparam int ZONE_W = PAGE_W + BLK_W;
    localparam int BLK_SH = OFF_W - BLK_W;

    logic is_erase;
    logic zone_bad;
    logic addr_bad;

    // Pick between zone decode and linear decode.
    always_comb begin
        is_erase = (op == OP_ERZ) || (op == OP_ERA);
        zone_bad = |zone[ZSEL_W-1:ZONE_W];
        addr_bad = |addr[ADDR_W-1:OFF_W+PAGE_W];
        if (is_erase) begin
            page      = zone[ZONE_W-1:BLK_W];
            offset    = {zone[BLK_W-1:0], {BLK_SH{1'b0}}};
            range_err = zone_bad;
        end else begin
            page      = addr[OFF_W+PAGE_W-1:OFF_W];
            offset    = addr[OFF_W-1:0];
            range_err = addr_bad;
        end
    end

endmodule

// File: rtl/pnor_poll_timer.sv
// Status-poll watchdog: counts poll cycles after a start pulse and flags
// when the limit-th poll is under way. Assumes limit >= 1.
module pnor_poll_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = (cnt >= limit - 1'b1);

    // Poll counter, cleared by start, held once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (start)            cnt <= '0;
        else if (run && !expired)  cnt <= cnt + 1'b1;
    end

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit)); // R11

endmodule

// File: rtl/pnor_bad_mask.sv
// Unusable-zone mask: marks one zone or all zones; only reset clears it.
module pnor_bad_mask #(
    parameter int ZONES  = 32,
    parameter int ZONE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_one,
    input  logic              set_all,
    input  logic [ZONE_W-1:0] zone,
    output logic [ZONES-1:0]  mask
);
    // Accumulate failure marks.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= '0;
        else if (set_all)  mask <= '1;
        else if (set_one)  mask <= mask | (ZONES'(1) << zone);
    end

    AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask & $past(mask)) == $past(mask))); // R9

    AST_MASK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_one && !set_all) |=> ((mask ^ $past(mask)) & ~(ZONES'(1) << $past(zone))) == '0); // R9

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (&mask)); // R10

endmodule

// File: rtl/pnor_seq.sv
// Paged NOR flash command sequencer (top). Accepts one host request at a
// time. It sets the window page, sends command cycles, polls status with a
// timeout, cleans up with clear-status and array mode, and keeps the
// unusable-zone mask. Assumes fl_rdata is valid in the cycle fl_re is high.
module pnor_seq
    import pnor_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PAGE_W    = 3,
    parameter int OFF_W     = 18,
    parameter int BLK_W     = 2,
    parameter int PROG_TMO  = 4000,
    parameter int ERASE_TMO = 400000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_op,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [7:0]                    req_wdata,
    output logic                          done,
    output logic                          err,
    output logic [7:0]                    rdata,
    output logic [(1<<(PAGE_W+BLK_W))-1:0] unusable,
    input  logic [7:0]                    sys_reg_in,
    output logic [7:0]                    sys_reg_wdata,
    output logic                          sys_reg_we,
    output logic [OFF_W-1:0]              fl_addr,
    output logic [7:0]                    fl_wdata,
    output logic                          fl_we,
    output logic                          fl_re,
    input  logic [7:0]                    fl_rdata
);
    localparam int ZONE_W  = PAGE_W + BLK_W;
    localparam int ZONES   = 1 << ZONE_W;
    localparam int ZSEL_W  = 8;
    localparam int TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
    localparam int CNT_W   = $clog2(TMO_MAX + 1);

    state_e              state;
    op_e                 op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          data_q;
    logic [ZSEL_W-1:0]   zone_q;
    logic                fail_q;
    logic                err_q;
    logic [7:0]          rdata_q;

    logic [PAGE_W-1:0]   page;
    logic [OFF_W-1:0]    offset;
    logic                range_err;
    logic                tmo;
    logic [CNT_W-1:0]    tmo_limit;
    logic                mark_one;
    logic                mark_all;
    logic                st_ready;
    logic                st_fail;

    pnor_addr_map #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
        .BLK_W(BLK_W), .ZSEL_W(ZSEL_W)
    ) u_map (
        .op(op_q), .addr(addr_q), .zone(zone_q),
        .page(page), .offset(offset), .range_err(range_err)
    );

    assign tmo_limit = (op_q == OP_PROG) ? CNT_W'(PROG_TMO) : CNT_W'(ERASE_TMO);

    pnor_poll_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start((state == S_PDAT) || (state == S_ECMD2)),
        .run(state == S_POLL),
        .limit(tmo_limit),
        .expired(tmo)
    );

    pnor_bad_mask #(.ZONES(ZONES), .ZONE_W(ZONE_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_one(mark_one), .set_all(mark_all),
        .zone(zone_q[ZONE_W-1:0]), .mask(unusable)
    );

    // Status byte decode.
    assign st_ready = fl_rdata[ST_READY_BIT];
    assign st_fail  = |(fl_rdata & ST_ERR_MASK);

    // Mask updates happen when a failed sequence finishes its cleanup.
    assign mark_one = (state == S_RDM) && fail_q && (op_q == OP_ERZ);
    assign mark_all = (state == S_RDM) && fail_q && (op_q != OP_ERZ);

    // Bus-side outputs decoded from the state.
    always_comb begin
        req_ready     = (state == S_IDLE);
        done          = (state == S_DONE);
        err           = err_q;
        rdata         = rdata_q;
        sys_reg_we    = (state == S_PAGE);
        sys_reg_wdata = (sys_reg_in & SYS_KEEP) | ((8'(page) << SYS_PAGE_LSB) & ~SYS_KEEP);
        fl_addr       = offset;
        fl_re         = (state == S_RD) || (state == S_PRD) ||
                        (state == S_POLL) || (state == S_VRF);
        fl_we         = 1'b0;
        fl_wdata      = CMD_ARRAY;
        unique case (state)
            S_PCMD:  begin fl_we = 1'b1; fl_wdata = CMD_PROG;   end
            S_PDAT:  begin fl_we = 1'b1; fl_wdata = data_q;     end
            S_ECMD1: begin fl_we = 1'b1; fl_wdata = CMD_ESETUP; end
            S_ECMD2: begin fl_we = 1'b1; fl_wdata = CMD_ECONF;  end
            S_CLR:   begin fl_we = 1'b1; fl_wdata = CMD_CLRST;  end
            S_RDM:   begin fl_we = 1'b1; fl_wdata = CMD_ARRAY;  end
            default: ;
        endcase
    end

    // Request sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            data_q  <= '0;
            zone_q  <= '0;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_wdata;
                    zone_q <= (op_e'(req_op) == OP_ERA) ? '0 : req_addr[ZSEL_W-1:0];
                    err_q  <= 1'b0;
                    fail_q <= 1'b0;
                    state  <= S_CHK;
                end
                S_CHK: begin
                    if (range_err) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        state <= S_PAGE;
                    end
                end
                S_PAGE: begin
                    unique case (op_q)
                        OP_READ: state <= S_RD;
                        OP_PROG: state <= S_PRD;
                        default: state <= S_ECMD1;
                    endcase
                end
                S_RD: begin
                    rdata_q <= fl_rdata;
                    state   <= S_DONE;
                end
                S_PRD: begin
                    if ((~fl_rdata & data_q) != 8'h00) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (fl_rdata == data_q) begin
                        state <= S_DONE;
                    end else begin
                        state <= S_PCMD;
                    end
                end
                S_PCMD:  state <= S_PDAT;
                S_PDAT:  state <= S_POLL;
                S_ECMD1: state <= S_ECMD2;
                S_ECMD2: state <= S_POLL;
                S_POLL: begin
                    if (st_ready) begin
                        fail_q <= st_fail;
                        state  <= S_CLR;
                    end else if (tmo) begin
                        fail_q <= 1'b1;
                        state  <= S_CLR;
                    end
                end
                S_CLR: state <= S_RDM;
                S_RDM: begin
                    if (fail_q) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (op_q == OP_PROG) begin
                        state <= S_VRF;
                    end else if (op_q == OP_ERA && zone_q != ZSEL_W'(ZONES - 1)) begin
                        zone_q <= zone_q + 1'b1;
                        state  <= S_PAGE;
                    end else begin
                        state <= S_DONE;
                    end
                end
                S_VRF: begin
                    if (fl_rdata != data_q) err_q <= 1'b1;
                    state <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_ERASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && fl_wdata == CMD_ESETUP && state == S_ECMD1)
        |=> (fl_we && fl_wdata == CMD_ECONF && $stable(fl_addr))); // R8

    AST_CLEAN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && fl_wdata == CMD_CLRST)
        |=> (fl_we && fl_wdata == CMD_ARRAY && $stable(fl_addr))); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_we && !fl_re && !done)); // R13

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R13

    AST_RANGE_NO_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHK && range_err) |=> (!sys_reg_we && !fl_we)); // R2

endmodule

// File: tb/pnor_seq_tb.sv
// Bench for pnor_seq with a small behavioural flash model. The model stores
// 512 bytes indexed by {page, offset[17:16], offset[3:0]}.
module pnor_seq_tb;
    localparam int PROG_TMO  = 20;
    localparam int ERASE_TMO = 50;
    localparam int PBUSY     = 3;
    localparam int EBUSY     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done, err;
    logic [7:0]  rdata;
    logic [31:0] unusable;
    logic [7:0]  sys_reg_wdata;
    logic        sys_reg_we;
    logic [17:0] fl_addr;
    logic [7:0]  fl_wdata, fl_rdata;
    logic        fl_we, fl_re;

    always #2.5 clk = ~clk;

    // Model state
    logic [7:0] mem [512];
    logic [7:0] sysreg = 8'hF5;
    logic       marr;
    int         pend, busy;
    logic [2:0] errb;
    logic       inj_fail = 0, inj_hang = 0, inj_noprog = 0;
    int         inj_zone = -1;
    int         n_wr = 0, n_sys = 0, n_st_rd = 0, n_erase = 0;
    int         erase_log [128];
    logic [7:0] last_w = 0, prev_w = 0;
    logic [17:0] last_a = 0, prev_a = 0;

    wire [8:0] midx = {sysreg[6:4], fl_addr[17:16], fl_addr[3:0]};
    wire [4:0] mzone = {sysreg[6:4], fl_addr[17:16]};
    assign fl_rdata = marr ? mem[midx] : {(busy == 0), 1'b0, errb, 3'b000};

    pnor_seq #(.PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .err(err), .rdata(rdata), .unusable(unusable),
        .sys_reg_in(sysreg), .sys_reg_wdata(sys_reg_wdata), .sys_reg_we(sys_reg_we),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    // Behavioural flash and system register.
    always @(posedge clk) begin
        if (sys_reg_we) begin sysreg <= sys_reg_wdata; n_sys <= n_sys + 1; end
        if (!rst_n) begin
            marr <= 1'b1; pend <= 0; busy <= 0; errb <= 3'b000;
        end else begin
            if (busy > 0 && !inj_hang) busy <= busy - 1;
            if (fl_re && !marr) n_st_rd <= n_st_rd + 1;
            if (fl_we) begin
                n_wr <= n_wr + 1;
                prev_w <= last_w; last_w <= fl_wdata;
                prev_a <= last_a; last_a <= fl_addr;
                if (pend == 1) begin
                    pend <= 0; marr <= 1'b0; busy <= PBUSY;
                    if (inj_fail) errb <= 3'b010;
                    else if (!inj_noprog) mem[midx] <= mem[midx] & fl_wdata;
                end else if (pend == 2) begin
                    pend <= 0; marr <= 1'b0;
                    if (fl_wdata == 8'hD0) begin
                        busy <= EBUSY;
                        erase_log[n_erase % 128] <= int'(mzone);
                        n_erase <= n_erase + 1;
                        if (inj_fail || int'(mzone) == inj_zone) errb <= 3'b010;
                        else for (int i = 0; i < 16; i++) mem[{mzone, i[3:0]}] <= 8'hFF;
                    end
                end else begin
                    case (fl_wdata)
                        8'h10: pend <= 1;
                        8'h20: pend <= 2;
                        8'h50: errb <= 3'b000;
                        8'hFF: marr <= 1'b1;
                        8'h70: marr <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Bench bookkeeping
    int checks = 0, fails = 0;
    logic [7:0] expm [512];
    logic r_err;
    logic [7:0] r_data;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 2));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        r_err = err; r_data = rdata;
    endtask

    function automatic logic [23:0] lin(input int pg, input int blk, input int lo);
        return 24'((pg << 18) | (blk << 16) | (12'h5A5 << 4) | lo);
    endfunction

    function automatic int eidx(input int pg, input int blk, input int lo);
        return (pg << 6) | (blk << 4) | lo;
    endfunction

    task automatic check_cleanup(input string tag);
        check({tag, " cleanup last"}, 32'(last_w), 32'hFF);
        check({tag, " cleanup prev"}, 32'(prev_w), 32'h50);
        check({tag, " cleanup addr"}, 32'(last_a), 32'(prev_a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int w0, s0, r0, e0, x;
        logic [7:0] ov, nv;
        for (int i = 0; i < 512; i++) begin mem[i] = pat(i); expm[i] = pat(i); end
        do_reset();
        @(negedge clk);
        // R13 reset state
        check("R13 ready after reset", 32'(req_ready), 1);
        check("R13 done after reset", 32'(done), 0);
        check("R13 mask after reset", unusable, 0);

        // R1 reads across every page, including the page-end roll-over
        for (int p = 0; p < 8; p++) begin
            do_req(2'd0, lin(p, p % 4, p), 8'h00);
            check("R1 read data", 32'(r_data), 32'(expm[eidx(p, p % 4, p)]));
            check("R1 read err", 32'(r_err), 0);
            check("R1 sysreg", 32'(sysreg), 32'(8'h85 | (p << 4)));
            if (p < 7) begin
                do_req(2'd0, 24'((p << 18) | 18'h3FFFF), 8'h00);
                check("R1 page last byte", 32'(r_data), 32'(expm[eidx(p, 3, 15)]));
                do_req(2'd0, 24'((p << 18) | 18'h3FFFF) + 24'd1, 8'h00);
                check("R1 carry next page", 32'(r_data), 32'(expm[eidx(p + 1, 0, 0)]));
                check("R1 carry sysreg", 32'(sysreg), 32'(8'h85 | ((p + 1) << 4)));
            end
        end
        @(negedge clk);
        check("R13 done one cycle", 32'(done), 0);
        check("R13 ready again", 32'(req_ready), 1);

        // R2 out of range
        for (int k = 0; k < 3; k++) begin
            s0 = n_sys; w0 = n_wr;
            do_req(k == 2 ? 2'd1 : 2'd0, 24'(24'h200000 << k), 8'h00);
            check("R2 range err", 32'(r_err), 1);
            check("R2 no sysreg write", 32'(n_sys - s0), 0);
            check("R2 no flash write", 32'(n_wr - w0), 0);
        end

        // R3 R4 R5 program screening and sequence
        for (int k = 0; k < 16; k++) begin
            int pg = k % 8, bk = (k / 2) % 4, ix;
            ix = eidx(pg, bk, k);
            ov = expm[ix];
            if (ov != 8'hFF) begin
                nv = ov | (~ov & (-(~ov)));
                w0 = n_wr;
                do_req(2'd1, lin(pg, bk, k), nv);
                check("R3 refuse 0to1 err", 32'(r_err), 1);
                check("R3 refuse no write", 32'(n_wr - w0), 0);
                check("R3 mask unchanged", unusable, 0);
            end
            w0 = n_wr;
            do_req(2'd1, lin(pg, bk, k), ov);
            check("R4 equal err", 32'(r_err), 0);
            check("R4 equal no write", 32'(n_wr - w0), 0);
            if (ov != 8'h00) begin
                nv = ov & (ov - 8'd1);
                w0 = n_wr; r0 = n_st_rd;
                do_req(2'd1, lin(pg, bk, k), nv);
                expm[ix] = nv;
                check("R5 program err", 32'(r_err), 0);
                check("R5 program writes", 32'(n_wr - w0), 4);
                check("R5 polled status", 32'(n_st_rd - r0 > 0), 1);
                check_cleanup("R12 program");
                do_req(2'd0, lin(pg, bk, k), 8'h00);
                check("R5 program readback", 32'(r_data), 32'(nv));
            end
        end

        // R6 status failure on program marks all zones
        x = eidx(2, 1, 7);
        ov = expm[x];
        if (ov == 8'h00) ov = 8'h00;
        inj_fail = 1;
        do_req(2'd1, lin(2, 1, 7), 8'h00);
        inj_fail = 0;
        check("R6 program fail err", 32'(r_err), (ov == 8'h00) ? 0 : 1);
        check("R6 program fail mask", unusable, (ov == 8'h00) ? 0 : 32'hFFFF_FFFF);
        check_cleanup("R12 program fail");

        // R7 verify mismatch
        do_reset();
        inj_noprog = 1;
        x = eidx(5, 2, 9);
        nv = expm[x] & (expm[x] - 8'd1);
        do_req(2'd1, lin(5, 2, 9), nv);
        inj_noprog = 0;
        check("R7 verify err", 32'(r_err), (expm[x] == 8'h00) ? 0 : 1);
        check("R7 verify mask", unusable, 0);

        // R11 program timeout
        do_reset();
        inj_hang = 1;
        r0 = n_st_rd;
        x = eidx(6, 3, 3);
        nv = expm[x] & (expm[x] - 8'd1);
        do_req(2'd1, lin(6, 3, 3), nv);
        inj_hang = 0;
        expm[x] = nv;
        check("R11 prog timeout err", 32'(r_err), 1);
        check("R11 prog poll count", 32'(n_st_rd - r0), PROG_TMO);
        check_cleanup("R11 prog timeout");
        repeat (20) @(negedge clk);

        // R8 erase every zone
        do_reset();
        for (int z = 0; z < 32; z++) begin
            w0 = n_wr; e0 = n_erase;
            do_req(2'd2, 24'(z), 8'h00);
            for (int i = 0; i < 16; i++) expm[(z << 4) | i] = 8'hFF;
            check("R8 erase err", 32'(r_err), 0);
            check("R8 erase writes", 32'(n_wr - w0), 4);
            check("R8 erase zone", 32'(erase_log[e0 % 128]), 32'(z));
            check_cleanup("R12 erase");
            do_req(2'd0, lin(z >> 2, z & 3, 5), 8'h00);
            check("R8 erased byte", 32'(r_data), 32'hFF);
            if (z < 31) begin
                do_req(2'd0, lin((z + 1) >> 2, (z + 1) & 3, 5), 8'h00);
                check("R8 neighbour kept", 32'(r_data), 32'(expm[((z + 1) << 4) | 5]));
            end
        end
        s0 = n_sys;
        do_req(2'd2, 24'd32, 8'h00);
        check("R8 zone 32 err", 32'(r_err), 1);
        do_req(2'd2, 24'd200, 8'h00);
        check("R8 zone 200 err", 32'(r_err), 1);
        check("R8 bad zone no sysreg", 32'(n_sys - s0), 0);

        // R9 single-zone failure and timeout
        inj_zone = 5;
        do_req(2'd2, 24'd5, 8'h00);
        inj_zone = -1;
        check("R9 zone fail err", 32'(r_err), 1);
        check("R9 zone fail mask", unusable, 32'h0000_0020);
        check_cleanup("R9 zone fail");
        inj_hang = 1;
        r0 = n_st_rd;
        do_req(2'd2, 24'd9, 8'h00);
        inj_hang = 0;
        check("R9 zone timeout err", 32'(r_err), 1);
        check("R9 zone timeout mask", unusable, 32'h0000_0220);
        check("R11 erase poll count", 32'(n_st_rd - r0), ERASE_TMO);
        check_cleanup("R11 erase timeout");
        repeat (20) @(negedge clk);

        // R10 erase all in order
        do_reset();
        e0 = n_erase;
        do_req(2'd3, 24'd0, 8'h00);
        check("R10 erase all err", 32'(r_err), 0);
        check("R10 erase all count", 32'(n_erase - e0), 32);
        for (int z = 0; z < 32; z++)
            check("R10 erase order", 32'(erase_log[(e0 + z) % 128]), 32'(z));
        check("R10 erase all mask", unusable, 0);

        // R10 stop at first failure
        inj_zone = 13;
        e0 = n_erase;
        do_req(2'd3, 24'd0, 8'h00);
        inj_zone = -1;
        check("R10 stop err", 32'(r_err), 1);
        check("R10 stop count", 32'(n_erase - e0), 14);
        check("R10 stop mask", unusable, 32'hFFFF_FFFF);
        check_cleanup("R10 stop");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule